// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative address translation cache. Every slot describes two neighbouring virtual pages, an even one and an odd one. Each half has its own physical frame, valid flag and dirty flag. A per-slot size mask widens both pages of the pair together, from 4 KB upward. A global flag lets a slot answer for every address-space identifier.

Translation is purely combinational. The caller presents a virtual address, the running 8-bit address-space identifier and a read/write flag. In the same cycle the unit returns a two-bit status. On a hit it also returns the physical address and the read and write permissions. A separate load port fills one slot, chosen by index, with all of its fields on a single clock edge. Refill policy belongs to the surrounding logic.

Top module: `tlbPairLookup`

## Requirements
- R1: After reset no slot is loaded, so every lookup reports status 1 (miss), whatever address and identifier are presented.
- R2: A loaded slot matches when its global flag is set or its identifier equals the lookup identifier, and the lookup address equals the slot's page-pair number in every bit above the effective mask. With no matching slot the status is 1 (miss).
- R3: The effective mask is the slot's size mask ORed with 0x1FFF. Its highest set bit picks the half of the pair: 0 selects the even half and 1 selects the odd half.
- R4: If the selected half's valid flag is clear, the status is 2 (invalid), for both reads and writes.
- R5: A write whose selected half is valid but clean gives status 3 (modified). A read of a valid clean half hits.
- R6: On a hit the status is 0. The physical address is the selected frame ORed with the lookup address bits below the select bit. Read permission is 1, and write permission equals the half's dirty flag. For any other status the address and both permissions are 0.
- R7: When several slots match, the one with the lowest index decides the result.
- R8: A load writes every field of the indexed slot on one clock edge, replacing what the slot held before. A lookup in the cycle of the load still sees the old contents, and the new contents take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset; empties all slots |
| lkVaddr | input | 32 | Virtual address to translate |
| lkAsid | input | 8 | Current address-space identifier |
| lkWrite | input | 1 | 1 for a write access, 0 for a read |
| lkStatus | output | 2 | 0 hit, 1 miss, 2 invalid, 3 modified |
| lkPaddr | output | 32 | Translated physical address; 0 unless hit |
| lkCanRead | output | 1 | Read permission granted |
| lkCanWrite | output | 1 | Write permission granted |
| wrEn | input | 1 | Load the slot named by wrIndex on this edge |
| wrIndex | input | 4 | Slot to load |
| wrPageMask | input | 32 | Size mask; bits above bit 12 widen the pair |
| wrVpn | input | 32 | Virtual page-pair number, aligned to the pair |
| wrGlobal | input | 1 | Match regardless of identifier |
| wrAsid | input | 8 | Identifier owning the slot |
| wrEvenFrame | input | 32 | Physical frame base of the even page |
| wrEvenValid | input | 1 | Even page valid |
| wrEvenDirty | input | 1 | Even page writable |
| wrOddFrame | input | 32 | Physical frame base of the odd page |
| wrOddValid | input | 1 | Odd page valid |
| wrOddDirty | input | 1 | Odd page writable |

## Verification
A load and a lookup can fall in the same cycle, and the lookup may target the very slot being loaded. The bench drives both together on an empty slot. It samples the combinational result before the edge and expects a miss. After the edge it samples again with the inputs unchanged and expects a hit built from the newly loaded frame. Overwriting a slot that was already matching is judged the same way, before and after the edge.

// File: rtl/tlbPairPkg.sv
package tlbPairPkg;
  localparam int TLB_ENTRIES = 16;
  localparam int VA_W = 32;
  localparam int PA_W = 32;
  localparam int ASID_W = 8;
  localparam int PAGE_SHIFT = 12;
  localparam int IDX_W = $clog2(TLB_ENTRIES);
  localparam logic [VA_W-1:0] BASE_MASK = VA_W'((64'd1 << (PAGE_SHIFT + 1)) - 64'd1);

  typedef enum logic [1:0] {
    ST_HIT      = 2'd0,
    ST_MISS     = 2'd1,
    ST_INVALID  = 2'd2,
    ST_MODIFIED = 2'd3
  } lookupStatus_e;

  typedef struct packed {
    logic [PA_W-1:0] frame;
    logic            valid;
    logic            dirty;
  } pageHalf_t;

  typedef struct packed {
    logic              occupied;
    logic              global;
    logic [ASID_W-1:0] asid;
    logic [VA_W-1:0]   vpn;
    logic [VA_W-1:0]   pageMask;
    pageHalf_t         even;
    pageHalf_t         odd;
  } tlbSlot_t;

  typedef struct packed {
    logic [TLB_ENTRIES-1:0] loadSlot;
    logic                   emitAddr;
  } ctrlStrobes_t;

  typedef struct packed {
    logic anyMatch;
    logic selValid;
    logic selDirty;
  } lookupFlags_t;
endpackage

// File: rtl/tlbPairCtrl.sv
module tlbPairCtrl
  import tlbPairPkg::*;
(
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIndex,
  input  logic             lkWrite,
  input  lookupFlags_t     flags,
  output ctrlStrobes_t     strobes,
  output lookupStatus_e    status,
  output logic             canRead,
  output logic             canWrite
);
  logic [TLB_ENTRIES-1:0] loadVec;

  for (genvar g = 0; g < TLB_ENTRIES; g++) begin : gLoad
    assign loadVec[g] = wrEn && (wrIndex == IDX_W'(g));
  end

  always_comb begin
    status = ST_HIT;
    if (!flags.anyMatch) begin
      status = ST_MISS;
    end else if (!flags.selValid) begin
      status = ST_INVALID;
    end else if (lkWrite && !flags.selDirty) begin
      status = ST_MODIFIED;
    end
  end

  always_comb begin
    strobes.loadSlot = loadVec;
    strobes.emitAddr = (status == ST_HIT);
    canRead  = strobes.emitAddr;
    canWrite = strobes.emitAddr && flags.selDirty;
  end
endmodule

// File: rtl/tlbPairDatapath.sv
module tlbPairDatapath
  import tlbPairPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [VA_W-1:0]   wrPageMask,
  input  logic [VA_W-1:0]   wrVpn,
  input  logic              wrGlobal,
  input  logic [ASID_W-1:0] wrAsid,
  input  pageHalf_t         wrEven,
  input  pageHalf_t         wrOdd,
  input  logic [VA_W-1:0]   lkVaddr,
  input  logic [ASID_W-1:0] lkAsid,
  output lookupFlags_t      flags,
  output logic [PA_W-1:0]   lkPaddr
);
  tlbSlot_t slots [TLB_ENTRIES];
  logic [VA_W-1:0] effMask [TLB_ENTRIES];
  logic [TLB_ENTRIES-1:0] hitVec;
  logic [TLB_ENTRIES-1:0] oddVec;
  logic [IDX_W-1:0] winner;
  pageHalf_t selHalf;
  logic [VA_W-1:0] offsetMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TLB_ENTRIES; i++) begin
        slots[i] <= '0;
      end
    end else begin
      for (int i = 0; i < TLB_ENTRIES; i++) begin
        if (strobes.loadSlot[i]) begin
          slots[i].occupied <= 1'b1;
          slots[i].global   <= wrGlobal;
          slots[i].asid     <= wrAsid;
          slots[i].vpn      <= wrVpn;
          slots[i].pageMask <= wrPageMask;
          slots[i].even     <= wrEven;
          slots[i].odd      <= wrOdd;
        end
      end
    end
  end

  for (genvar g = 0; g < TLB_ENTRIES; g++) begin : gMatch
    logic idOk;
    logic vpnOk;
    assign effMask[g] = slots[g].pageMask | BASE_MASK;
    assign idOk  = slots[g].global || (slots[g].asid == lkAsid);
    assign vpnOk = ((slots[g].vpn ^ lkVaddr) & ~effMask[g]) == '0;
    assign hitVec[g] = slots[g].occupied && idOk && vpnOk;
    assign oddVec[g] = |(lkVaddr & effMask[g] & ~(effMask[g] >> 1));
  end

  always_comb begin
    winner = '0;
    for (int i = TLB_ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) winner = IDX_W'(i);
    end
  end

  always_comb begin
    selHalf    = oddVec[winner] ? slots[winner].odd : slots[winner].even;
    offsetMask = effMask[winner] >> 1;
    flags.anyMatch = |hitVec;
    flags.selValid = selHalf.valid;
    flags.selDirty = selHalf.dirty;
    lkPaddr = strobes.emitAddr ? (selHalf.frame | PA_W'(lkVaddr & offsetMask)) : '0;
  end
endmodule

// File: rtl/tlbPairLookup.sv
module tlbPairLookup
  import tlbPairPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [VA_W-1:0]   lkVaddr,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic              lkWrite,
  output logic [1:0]        lkStatus,
  output logic [PA_W-1:0]   lkPaddr,
  output logic              lkCanRead,
  output logic              lkCanWrite,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIndex,
  input  logic [VA_W-1:0]   wrPageMask,
  input  logic [VA_W-1:0]   wrVpn,
  input  logic              wrGlobal,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic [PA_W-1:0]   wrEvenFrame,
  input  logic              wrEvenValid,
  input  logic              wrEvenDirty,
  input  logic [PA_W-1:0]   wrOddFrame,
  input  logic              wrOddValid,
  input  logic              wrOddDirty
);
  ctrlStrobes_t  strobes;
  lookupFlags_t  flags;
  lookupStatus_e status;
  pageHalf_t     evenIn;
  pageHalf_t     oddIn;

  assign evenIn = '{frame: wrEvenFrame, valid: wrEvenValid, dirty: wrEvenDirty};
  assign oddIn  = '{frame: wrOddFrame,  valid: wrOddValid,  dirty: wrOddDirty};
  assign lkStatus = status;

  tlbPairCtrl uCtrl (
    .wrEn     (wrEn),
    .wrIndex  (wrIndex),
    .lkWrite  (lkWrite),
    .flags    (flags),
    .strobes  (strobes),
    .status   (status),
    .canRead  (lkCanRead),
    .canWrite (lkCanWrite)
  );

  tlbPairDatapath uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrPageMask (wrPageMask),
    .wrVpn      (wrVpn),
    .wrGlobal   (wrGlobal),
    .wrAsid     (wrAsid),
    .wrEven     (evenIn),
    .wrOdd      (oddIn),
    .lkVaddr    (lkVaddr),
    .lkAsid     (lkAsid),
    .flags      (flags),
    .lkPaddr    (lkPaddr)
  );
endmodule

// File: rtl/tlbPairLookupChecker.sv
module tlbPairLookupChecker (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] lkVaddr,
  input logic        lkWrite,
  input logic [1:0]  lkStatus,
  input logic [31:0] lkPaddr,
  input logic        lkCanRead,
  input logic        lkCanWrite,
  input logic        wrEn
);
  logic anyLoaded;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) anyLoaded <= 1'b0;
    else if (wrEn) anyLoaded <= 1'b1;
  end

  p_empty_misses_r1: assert property (@(posedge clk) disable iff (!rstN)
    !anyLoaded |-> lkStatus == 2'd1);

  p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    lkStatus == 2'd0 |-> lkPaddr[11:0] == lkVaddr[11:0]);

  p_modified_only_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    lkStatus == 2'd3 |-> lkWrite);

  p_write_hit_writable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lkStatus == 2'd0 && lkWrite) |-> lkCanWrite);

  p_hit_readable_r6: assert property (@(posedge clk) disable iff (!rstN)
    lkStatus == 2'd0 |-> lkCanRead);

  p_fault_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    lkStatus != 2'd0 |-> (lkPaddr == '0 && !lkCanRead && !lkCanWrite));
endmodule

bind tlbPairLookup tlbPairLookupChecker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .lkVaddr    (lkVaddr),
  .lkWrite    (lkWrite),
  .lkStatus   (lkStatus),
  .lkPaddr    (lkPaddr),
  .lkCanRead  (lkCanRead),
  .lkCanWrite (lkCanWrite),
  .wrEn       (wrEn)
);

// File: tb/tlbPairLookup_test.sv
`timescale 1ns/1ps
module tlbPairLookup_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic [31:0] lkVaddr = 0;
  logic [7:0]  lkAsid = 0;
  logic        lkWrite = 0;
  logic [1:0]  lkStatus;
  logic [31:0] lkPaddr;
  logic        lkCanRead, lkCanWrite;
  logic        wrEn = 0;
  logic [3:0]  wrIndex = 0;
  logic [31:0] wrPageMask = 0, wrVpn = 0, wrEvenFrame = 0, wrOddFrame = 0;
  logic        wrGlobal = 0, wrEvenValid = 0, wrEvenDirty = 0, wrOddValid = 0, wrOddDirty = 0;
  logic [7:0]  wrAsid = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tlbPairLookup uut (.*);

  task automatic checkOut(string req, logic [1:0] st, logic [31:0] pa, logic rd, logic wr);
    checks++;
    if (lkStatus !== st || lkPaddr !== pa || lkCanRead !== rd || lkCanWrite !== wr) begin
      fails++;
      $display("FAIL %s: got st=%0d pa=%h rd=%b wr=%b, expected st=%0d pa=%h rd=%b wr=%b",
               req, lkStatus, lkPaddr, lkCanRead, lkCanWrite, st, pa, rd, wr);
    end
  endtask

  task automatic look(logic [31:0] va, logic [7:0] id, logic w);
    @(negedge clk);
    lkVaddr = va; lkAsid = id; lkWrite = w;
    #1;
  endtask

  task automatic load(int idx, logic [31:0] msk, logic [31:0] vpn, logic g, logic [7:0] id,
                      logic [31:0] ef, logic ev, logic ed, logic [31:0] of, logic ov, logic od);
    @(negedge clk);
    wrEn = 1; wrIndex = 4'(idx); wrPageMask = msk; wrVpn = vpn; wrGlobal = g; wrAsid = id;
    wrEvenFrame = ef; wrEvenValid = ev; wrEvenDirty = ed;
    wrOddFrame = of; wrOddValid = ov; wrOddDirty = od;
    @(posedge clk);
    #1 wrEn = 0;
  endtask

  task automatic testReset();
    look(32'h0, 8'h0, 0);          checkOut("R1 reset va0", 2'd1, 0, 0, 0);
    look(32'h0040_0123, 8'h5, 1);  checkOut("R1 reset write", 2'd1, 0, 0, 0);
  endtask

  task automatic testSmallPage();
    load(0, 32'h0, 32'h0040_0000, 0, 8'h5, 32'h1000_0000, 1, 1, 32'h2000_0000, 1, 0);
    look(32'h0040_0123, 8'h5, 0);  checkOut("R6 even read", 2'd0, 32'h1000_0123, 1, 1);
    look(32'h0040_1abc, 8'h5, 0);  checkOut("R3 odd read clean", 2'd0, 32'h2000_0abc, 1, 0);
    look(32'h0040_1abc, 8'h5, 1);  checkOut("R5 odd write clean", 2'd3, 0, 0, 0);
    look(32'h0040_0123, 8'h6, 0);  checkOut("R2 asid mismatch", 2'd1, 0, 0, 0);
    look(32'h0040_2000, 8'h5, 0);  checkOut("R2 next pair", 2'd1, 0, 0, 0);
  endtask

  task automatic testGlobal();
    load(1, 32'h0, 32'h0080_0000, 1, 8'h9, 32'h0, 0, 0, 32'h3000_0000, 1, 1);
    look(32'h0080_0010, 8'd77, 0); checkOut("R4 even invalid", 2'd2, 0, 0, 0);
    look(32'h0080_0010, 8'd77, 1); checkOut("R4 invalid write", 2'd2, 0, 0, 0);
    look(32'h0080_1ff8, 8'd77, 1); checkOut("R2 global write hit", 2'd0, 32'h3000_0ff8, 1, 1);
  endtask

  task automatic testLargePage();
    load(2, 32'h0001_e000, 32'h0100_0000, 0, 8'h5, 32'h4000_0000, 1, 1, 32'h5000_0000, 1, 1);
    look(32'h0100_f004, 8'h5, 0);  checkOut("R3 64K even", 2'd0, 32'h4000_f004, 1, 1);
    look(32'h0101_2345, 8'h5, 1);  checkOut("R3 64K odd", 2'd0, 32'h5000_2345, 1, 1);
    look(32'h0102_0000, 8'h5, 0);  checkOut("R3 beyond pair", 2'd1, 0, 0, 0);
  endtask

  task automatic testPriority();
    load(7, 32'h0, 32'h0200_0000, 1, 8'h0, 32'h7000_0000, 1, 1, 32'h0, 0, 0);
    load(3, 32'h0, 32'h0200_0000, 1, 8'h0, 32'h6000_0000, 1, 0, 32'h0, 0, 0);
    look(32'h0200_0044, 8'h3, 0);  checkOut("R7 lowest wins", 2'd0, 32'h6000_0044, 1, 0);
    look(32'h0200_0044, 8'h3, 1);  checkOut("R7 lowest clean", 2'd3, 0, 0, 0);
    load(3, 32'h0, 32'h0300_0000, 1, 8'h0, 32'h6000_0000, 1, 0, 32'h0, 0, 0);
    look(32'h0200_0044, 8'h3, 1);  checkOut("R8 overwrite", 2'd0, 32'h7000_0044, 1, 1);
    load(15, 32'h0, 32'h0500_0000, 0, 8'h2, 32'h0, 0, 0, 32'h0800_0000, 1, 1);
    look(32'h0500_1001, 8'h2, 0);  checkOut("R2 last slot", 2'd0, 32'h0800_0001, 1, 1);
  endtask

  task automatic testSameCycle();
    @(negedge clk);
    lkVaddr = 32'h0400_0abc; lkAsid = 8'h4; lkWrite = 0;
    wrEn = 1; wrIndex = 4'd8; wrPageMask = 0; wrVpn = 32'h0400_0000; wrGlobal = 0; wrAsid = 8'h4;
    wrEvenFrame = 32'h0900_0000; wrEvenValid = 1; wrEvenDirty = 1;
    wrOddFrame = 0; wrOddValid = 0; wrOddDirty = 0;
    #1 checkOut("R8 same-cycle old", 2'd1, 0, 0, 0);
    @(posedge clk);
    #1 wrEn = 0;
    checkOut("R8 next-cycle new", 2'd0, 32'h0900_0abc, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testSmallPage();
    testGlobal();
    testLargePage();
    testPriority();
    testSameCycle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule